// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block turns GPIO input pins into one interrupt request for the CPU. The pins are grouped in banks of eight, and there are twenty-one such groups by default. Every pin first passes through a two-flop synchroniser. A per-pin trigger code then chooses what counts as an event: a level (low or high) or an edge (falling, rising or either). Each event latches a bit in its group's pending word. Software sees the block as three banks of 32-bit words on a simple register bus: trigger configuration, mask and pending.

A pin raises the CPU interrupt only while its pending bit is set and its mask bit is clear. The single interrupt output is the registered OR of all such pins across every group. Software services a pin by writing a 1 to its pending bit. A pin in a level mode whose level is still active sets its bit again straight away, so software must remove the level condition before the bit stays cleared.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every trigger field reads 0, every mask word reads 0x000000FF, every pending word reads 0 and `irq_o` is 0. While in reset, the synchroniser stages hold 1, so pins that are held high set nothing.
- R2: Group g's configuration word is at byte address 0x700+4g, its mask word at 0x900+4g and its pending word at 0xA00+4g. Pin p's 4-bit trigger code sits in configuration bits [4p+3:4p]. Mask and pending words use bit p for pin p, and bits 31:8 read as 0.
- R3: Trigger code 0 (low level) sets the pending bit on every cycle in which the synchronised pin is 0, so a clear written while the pin is still low is overridden.
- R4: Trigger code 1 (high level) sets the pending bit on every cycle in which the synchronised pin is 1.
- R5: Trigger code 2 sets the pending bit once per 1-to-0 transition of the synchronised pin, and trigger code 3 sets it once per 0-to-1 transition. A steady pin sets nothing after a clear.
- R6: Trigger code 4 sets the pending bit once on each transition of the synchronised pin, in either direction.
- R7: Trigger codes 5 to 15 never set the pending bit, whatever the pin does.
- R8: Writing a 1 to a pending bit clears it, and writing a 0 leaves it unchanged. When a clear and a new event for the same pin fall in the same cycle, the bit stays set.
- R9: A mask bit of 1 keeps its pin out of `irq_o`, although the pending bit still latches. A mask bit of 0 lets the pin through.
- R10: `irq_o` is the OR, over all groups, of pending bits whose mask bit is clear. It is registered, so it follows a change in pending or mask one cycle later.
- R11: A pin change that is set up before clock edge n shows in the pending word after edge n+2, and never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gpio_i | input | NUM_GROUPS*PINS_PER_GROUP | Raw pin inputs. Pin p of group g is bit 8g+p |
| bus_addr | input | ADDR_W | Byte address of the register being accessed |
| bus_wen | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational. Unmapped addresses read 0 |
| irq_o | output | 1 | Combined interrupt request to the CPU |

## Verification
Each trigger code is driven with a pin that falls, then rises, then stays steady. A level mode is told apart from an edge mode by whether the bit comes back after a clear. An edge mode is told apart from the both-edges mode by which direction of change sets the bit. Codes 5 to 15 get the same toggles and must leave pending at 0. A configuration word that gives each pin a different code shows whether the fields sit at the right bit positions. Writes of partial and all-zero clear patterns, and a clear timed into the same cycle as a rising event, separate a correct write-one-to-clear with set priority from the faulty variants. The pin-to-pending latency and the extra register cycle on `irq_o` are each sampled on the exact edge where the value must change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int FIELD_W = 4;
   localparam int WORD_W  = 32;

   typedef enum logic [FIELD_W-1:0] {
      TRIG_LVL_LO = 4'd0,
      TRIG_LVL_HI = 4'd1,
      TRIG_FALL   = 4'd2,
      TRIG_RISE   = 4'd3,
      TRIG_ANY    = 4'd4
   } trig_mode_e;

   // Event for one pin, given its code and synchronised value now and one cycle ago.
   function automatic logic trig_event(input logic [FIELD_W-1:0] code,
                                       input logic cur, input logic prev);
      logic hit;
      case (code)
         TRIG_LVL_LO: hit = ~cur;
         TRIG_LVL_HI: hit = cur;
         TRIG_FALL:   hit = ~cur & prev;
         TRIG_RISE:   hit = cur & ~prev;
         TRIG_ANY:    hit = cur ^ prev;
         default:     hit = 1'b0;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int   WIDTH   = 8,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] prev
);

   localparam int DEPTH = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_irq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) chain[i] <= {WIDTH{RST_VAL}};
      end else begin
         chain[0] <= din;
         for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
      end
   end

   assign cur  = chain[STAGES-1];
   assign prev = chain[STAGES];

endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group
   import gpio_irq_pkg::*;
#(
   parameter int PINS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_cfg,
   input  logic                wr_mask,
   input  logic                wr_pend,
   input  logic [WORD_W-1:0]   wdata,
   input  logic [PINS-1:0]     pin_cur,
   input  logic [PINS-1:0]     pin_prev,
   output logic [WORD_W-1:0]   cfg_q,
   output logic [PINS-1:0]     mask_q,
   output logic [PINS-1:0]     pend_q
);

   localparam int CFG_BITS = PINS * FIELD_W;

   if (CFG_BITS != WORD_W) begin : g_bad_pins
      $error("gpio_irq_group: PINS trigger fields must fill one word exactly");
   end

   logic [PINS-1:0] evt;
   logic [PINS-1:0] clr;

   for (genvar p = 0; p < PINS; p++) begin : g_pin
      assign evt[p] = trig_event(cfg_q[p*FIELD_W +: FIELD_W], pin_cur[p], pin_prev[p]);
   end

   assign clr = wr_pend ? wdata[PINS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         mask_q <= '1;
         pend_q <= '0;
      end else begin
         if (wr_cfg)  cfg_q  <= wdata;
         if (wr_mask) mask_q <= wdata[PINS-1:0];
         pend_q <= (pend_q & ~clr) | evt;
      end
   end

   AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((pend_q & $past(evt)) == $past(evt))); // R8

   AST_ONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pend && |(wdata[PINS-1:0] & ~evt)) |=> ((pend_q & $past(wdata[PINS-1:0] & ~evt)) == '0)); // R8

   AST_ZERO_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pend && wdata[PINS-1:0] == '0 && evt == '0) |=> (pend_q == $past(pend_q))); // R8

   AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mask |=> $stable(mask_q)); // R9

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int NUM_GROUPS     = 21,
   parameter int PINS_PER_GROUP = 8,
   parameter int SYNC_STAGES    = 2,
   parameter int ADDR_W         = 12,
   parameter int CFG_BASE       = 'h700,
   parameter int MASK_BASE      = 'h900,
   parameter int PEND_BASE      = 'hA00
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [NUM_GROUPS*PINS_PER_GROUP-1:0]   gpio_i,
   input  logic [ADDR_W-1:0]                      bus_addr,
   input  logic                                   bus_wen,
   input  logic [31:0]                            bus_wdata,
   output logic [31:0]                            bus_rdata,
   output logic                                   irq_o
);

   localparam int NUM_PINS  = NUM_GROUPS * PINS_PER_GROUP;
   localparam int BANK_SPAN = NUM_GROUPS * 4;

   if (PINS_PER_GROUP * FIELD_W != WORD_W) begin : g_bad_group
      $error("gpio_irq_ctrl: trigger fields of a group must fill one word");
   end
   if (CFG_BASE + BANK_SPAN > MASK_BASE || MASK_BASE + BANK_SPAN > PEND_BASE) begin : g_bad_map
      $error("gpio_irq_ctrl: register banks overlap");
   end
   if (PEND_BASE + BANK_SPAN > (1 << ADDR_W)) begin : g_bad_addr
      $error("gpio_irq_ctrl: ADDR_W too narrow for the register map");
   end

   logic [NUM_PINS-1:0]       pin_cur, pin_prev;
   logic [WORD_W-1:0]         cfg_w  [NUM_GROUPS];
   logic [PINS_PER_GROUP-1:0] mask_w [NUM_GROUPS];
   logic [PINS_PER_GROUP-1:0] pend_w [NUM_GROUPS];
   logic                      any_active;
   logic                      pend_any;
   logic                      mask_all;

   gpio_irq_sync #(
      .WIDTH   (NUM_PINS),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (gpio_i),
      .cur  (pin_cur),
      .prev (pin_prev)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_BASE  + 4 * g);
      localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_BASE + 4 * g);
      localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(PEND_BASE + 4 * g);

      gpio_irq_group #(
         .PINS(PINS_PER_GROUP)
      ) u_group (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_cfg  (bus_wen && bus_addr == A_CFG),
         .wr_mask (bus_wen && bus_addr == A_MASK),
         .wr_pend (bus_wen && bus_addr == A_PEND),
         .wdata   (bus_wdata),
         .pin_cur (pin_cur [g*PINS_PER_GROUP +: PINS_PER_GROUP]),
         .pin_prev(pin_prev[g*PINS_PER_GROUP +: PINS_PER_GROUP]),
         .cfg_q   (cfg_w[g]),
         .mask_q  (mask_w[g]),
         .pend_q  (pend_w[g])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (bus_addr == ADDR_W'(CFG_BASE + 4 * g))  bus_rdata = cfg_w[g];
         if (bus_addr == ADDR_W'(MASK_BASE + 4 * g)) bus_rdata = WORD_W'(mask_w[g]);
         if (bus_addr == ADDR_W'(PEND_BASE + 4 * g)) bus_rdata = WORD_W'(pend_w[g]);
      end
   end

   always_comb begin
      any_active = 1'b0;
      pend_any   = 1'b0;
      mask_all   = 1'b1;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         any_active = any_active | (|(pend_w[g] & ~mask_w[g]));
         pend_any   = pend_any | (|pend_w[g]);
         mask_all   = mask_all & (&mask_w[g]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= any_active;
   end

   AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(pend_any)); // R10

   AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mask_all) |-> !irq_o); // R9

   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |=> (!irq_o || !$past(rst_n, 1) && rst_n)); // R1

endmodule

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;

   localparam int G = 21;
   localparam int P = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [G*P-1:0]  gpio_i = '1;
   logic [11:0]     bus_addr = '0;
   logic            bus_wen = 1'b0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic            irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   gpio_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .gpio_i(gpio_i),
      .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   function automatic logic [11:0] a_cfg (int g); return 12'h700 + 12'(g * 4); endfunction
   function automatic logic [11:0] a_mask(int g); return 12'h900 + 12'(g * 4); endfunction
   function automatic logic [11:0] a_pend(int g); return 12'hA00 + 12'(g * 4); endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(a_cfg(0), d);   check("R1 cfg reset", d, 32'h0);
      rd(a_mask(5), d);  check("R1 mask reset", d, 32'h0000_00FF);
      rd(a_pend(20), d); check("R1 pend reset", d, 32'h0);
      check("R1 irq reset", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_layout;
      logic [31:0] d;
      wr(a_cfg(3), 32'h7654_3210);
      rd(a_cfg(3), d);  check("R2 cfg readback", d, 32'h7654_3210);
      idle(4);
      // pins high: only pin1 (code 1, high level) may be pending
      rd(a_pend(3), d); check("R2 field position", d, 32'h0000_0002);
      wr(a_cfg(3), 32'h0);
      wr(a_pend(3), 32'hFF);
      rd(a_pend(3), d); check("R2 pend clear", d, 32'h0);
      wr(a_mask(3), 32'hFFFF_FF5A);
      rd(a_mask(3), d); check("R2 mask upper bits zero", d, 32'h0000_005A);
      wr(a_mask(3), 32'hFF);
   endtask

   task automatic t_level_low;
      logic [31:0] d;
      @(negedge clk) gpio_i[1*P+2] = 1'b0;
      rd(a_pend(1), d); check("R11 after 1 edge", d, 32'h0);
      rd(a_pend(1), d); check("R11 after 2 edges", d, 32'h0);
      rd(a_pend(1), d); check("R3 R11 after 3 edges", d, 32'h4);
      wr(a_pend(1), 32'h4);
      rd(a_pend(1), d); check("R3 level low reasserts", d, 32'h4);
      @(negedge clk) gpio_i[1*P+2] = 1'b1;
      idle(4);
      wr(a_pend(1), 32'h4);
      idle(2);
      rd(a_pend(1), d); check("R3 cleared after release", d, 32'h0);
   endtask

   task automatic t_level_high;
      logic [31:0] d;
      wr(a_cfg(2), 32'h1);
      idle(2);
      rd(a_pend(2), d); check("R4 high level sets", d, 32'h1);
      wr(a_pend(2), 32'h1);
      rd(a_pend(2), d); check("R4 high level reasserts", d, 32'h1);
      @(negedge clk) gpio_i[2*P+0] = 1'b0;
      idle(4);
      wr(a_pend(2), 32'h1);
      idle(3);
      rd(a_pend(2), d); check("R4 low pin leaves clear", d, 32'h0);
   endtask

   task automatic t_edges;
      logic [31:0] d;
      wr(a_cfg(4), 32'h0000_0032);
      @(negedge clk) begin gpio_i[4*P+0] = 1'b0; gpio_i[4*P+1] = 1'b0; end
      idle(5);
      rd(a_pend(4), d); check("R5 falling only on pin0", d, 32'h1);
      wr(a_pend(4), 32'h3);
      idle(3);
      rd(a_pend(4), d); check("R5 no retrigger while low", d, 32'h0);
      @(negedge clk) begin gpio_i[4*P+0] = 1'b1; gpio_i[4*P+1] = 1'b1; end
      idle(5);
      rd(a_pend(4), d); check("R5 rising only on pin1", d, 32'h2);
      wr(a_pend(4), 32'h3);
      idle(3);
      rd(a_pend(4), d); check("R5 no retrigger while high", d, 32'h0);
   endtask

   task automatic t_both;
      logic [31:0] d;
      wr(a_cfg(5), 32'h0000_4000);
      @(negedge clk) gpio_i[5*P+3] = 1'b0;
      idle(5);
      rd(a_pend(5), d); check("R6 falling sets", d, 32'h8);
      wr(a_pend(5), 32'h8);
      @(negedge clk) gpio_i[5*P+3] = 1'b1;
      idle(5);
      rd(a_pend(5), d); check("R6 rising sets", d, 32'h8);
      wr(a_pend(5), 32'h8);
      idle(3);
      rd(a_pend(5), d); check("R6 steady clear", d, 32'h0);
   endtask

   task automatic t_disabled;
      logic [31:0] d;
      wr(a_cfg(6), 32'hFEDC_BA95);
      @(negedge clk) gpio_i[6*P +: P] = 8'h00;
      idle(5);
      rd(a_pend(6), d); check("R7 codes 5-15 ignore low", d, 32'h0);
      @(negedge clk) gpio_i[6*P +: P] = 8'hFF;
      idle(5);
      rd(a_pend(6), d); check("R7 codes 5-15 ignore high", d, 32'h0);
   endtask

   task automatic t_w1c;
      logic [31:0] d;
      wr(a_cfg(7), 32'h0000_4444);
      @(negedge clk) gpio_i[7*P +: 4] = 4'h0;
      idle(5);
      rd(a_pend(7), d); check("R8 four pins pending", d, 32'hF);
      wr(a_pend(7), 32'h5);
      rd(a_pend(7), d); check("R8 partial clear", d, 32'hA);
      wr(a_pend(7), 32'h0);
      rd(a_pend(7), d); check("R8 zero write no effect", d, 32'hA);
      // rising event on pin1 arrives in the very cycle the clear of bit1 is sampled
      @(negedge clk) gpio_i[7*P+1] = 1'b1;
      @(negedge clk);
      wr(a_pend(7), 32'h2);
      idle(2);
      rd(a_pend(7), d); check("R8 set wins over clear", d, 32'hA);
      wr(a_pend(7), 32'hF);
      rd(a_pend(7), d); check("R8 full clear", d, 32'h0);
   endtask

   task automatic t_mask_irq;
      logic [31:0] d;
      wr(a_cfg(20), 32'h3000_0000);
      @(negedge clk) gpio_i[20*P+7] = 1'b0;
      idle(4);
      rd(a_pend(20), d); check("R5 no rise no pend", d, 32'h0);
      @(negedge clk) gpio_i[20*P+7] = 1'b1;
      idle(5);
      rd(a_pend(20), d); check("R9 pend latches while masked", d, 32'h80);
      check("R9 masked irq low", {31'b0, irq_o}, 32'h0);
      wr(a_mask(20), 32'h7F);
      check("R10 irq one cycle late", {31'b0, irq_o}, 32'h0);
      idle(1);
      check("R10 irq after unmask", {31'b0, irq_o}, 32'h1);
      wr(a_pend(20), 32'h80);
      check("R10 irq held one cycle", {31'b0, irq_o}, 32'h1);
      idle(1);
      check("R10 irq drops after clear", {31'b0, irq_o}, 32'h0);
      wr(a_mask(20), 32'hFF);
      // second group: falling event on group 4 pin0, then unmask it
      @(negedge clk) gpio_i[4*P+0] = 1'b0;
      idle(5);
      check("R9 other group masked", {31'b0, irq_o}, 32'h0);
      wr(a_mask(4), 32'hFE);
      idle(1);
      check("R10 OR across groups", {31'b0, irq_o}, 32'h1);
      wr(a_mask(4), 32'hFF);
      idle(1);
      check("R9 remask blocks", {31'b0, irq_o}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_layout();
      t_level_low();
      t_level_high();
      t_edges();
      t_both();
      t_disabled();
      t_w1c();
      t_mask_irq();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog got=timeout exp=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule